// File: doc/BRIEF.md
# PHY Bring-up and Link Status Sequencer

This block drives an external MDIO frame master to find an Ethernet PHY and bring it up. It also answers link queries. A host issues one command at a time: find the PHY, reset it, run auto-negotiation, read link state, read speed and duplex, program the advertised abilities, or switch loopback on or off. The block turns each command into a fixed series of register reads and writes. Each access is handed to the frame master with a request that is held until the master returns a one-cycle done pulse, together with read data.

Results are kept in registered outputs that hold until the next command of the same kind: the PHY address, an absent flag, link up, 100 Mb/s, full duplex, negotiation complete and negotiation timeout. The loopback command also returns the control register value read after the write, on `rsp_data`.

Top module: `phy_link_mgr`

## Requirements
- R1: Probe reads register 2 at each address from ADDR_MIN upward. It stops at the first accepted address, reports that address on `addr_out` with `phy_absent` low, and reads no higher address.
- R2: A register 2 value of 16'hFFFF or 16'h0000 rejects that address, and the scan moves on to the next address.
- R3: When no address in the range is accepted, `addr_out` is 8'hFF and `phy_absent` is high. These are also the values after reset.
- R4: Reset writes 16'h8000 to register 0, then writes 16'h1280 to register 0 (bit 12 autoneg enable, bit 9 restart, bit 7 collision test).
- R5: Auto-negotiate reads register 0 and writes back that value with bits 12 and 9 set. It then reads register 1 until bit 5 is set, and then raises `an_done`.
- R6: Consecutive register 1 polls are separated by at least POLL_GAP clock cycles.
- R7: If POLL_LIMIT reads of register 1 all show bit 5 clear, the block raises `an_timeout`, leaves `an_done` low, and makes no further polls.
- R8: The link query reads register 1 and sets `link_up` to bit 2.
- R9: The speed query reads register 5'h12. It sets `full_dup` to bit 11 and `spd_100` to bit 10.
- R10: Advertise reads register 4 and sets bits 8..5. It clears bits 8 and 7 when `cmd_arg[1]` (100M) is low, and clears bits 8 and 6 when `cmd_arg[0]` (full duplex) is low. It then writes the result back.
- R11: Loopback reads register 0. It writes the value back with bit 14 set when `cmd_arg[0]` is 1, or with bit 14 cleared (never toggled) when it is 0. It then reads register 0 again and returns that value on `rsp_data`.
- R12: `cmd_op` codes are 0 probe, 1 reset, 2 auto-negotiate, 3 link, 4 speed/duplex, 5 advertise, 6 loopback. A command is taken only while `cmd_ready` is high, and `cmd_done` pulses for one cycle when the block is idle again.
- R13: `mdio_req` stays high, with its address and write data steady, until `mdio_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 2 | Command argument (advertise: [1]=100M, [0]=full duplex; loopback: [0]=enable) |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Register 0 value read back by loopback |
| mdio_req | output | 1 | Access request to frame master |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | PHY address of the access |
| mdio_reg | output | 5 | Register address of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | Access finished pulse |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| addr_out | output | 8 | Found PHY address, 8'hFF when absent |
| phy_absent | output | 1 | No PHY found |
| link_up | output | 1 | Link is up |
| spd_100 | output | 1 | Link runs at 100 Mb/s |
| full_dup | output | 1 | Link is full duplex |
| an_done | output | 1 | Auto-negotiation completed |
| an_timeout | output | 1 | Auto-negotiation poll limit reached |

## Verification
The bench places the PHY behind an all-ones ID and then behind an all-zeros ID, so a scan that accepts either value would stop too early. It also checks that no address past the hit is read, which catches a scan that overruns. Loopback is disabled twice in a row: a design that toggles bit 14 would set it again on the second disable. Negotiation is run against a PHY that never completes. A design without a poll limit would hang, and a limit that is off by one shows up as a wrong count of status reads. The gap between status polls is measured, which catches a delay that is missing or too short.

// File: rtl/phy_mgr_pkg.sv
package phy_mgr_pkg;

  typedef enum logic [2:0] {
    OP_PROBE  = 3'd0,
    OP_RESET  = 3'd1,
    OP_ANEG   = 3'd2,
    OP_LINK   = 3'd3,
    OP_SPEED  = 3'd4,
    OP_ADVERT = 3'd5,
    OP_LOOP   = 3'd6
  } op_t;

  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ID1  = 5'd2;
  localparam logic [4:0] RA_ADV  = 5'd4;
  localparam logic [4:0] RA_DIAG = 5'h12;

  localparam logic [15:0] CT_SOFT_RST   = 16'h8000;
  localparam logic [15:0] CT_LOOP       = 16'h4000;
  localparam logic [15:0] CT_AN_EN      = 16'h1000;
  localparam logic [15:0] CT_AN_RESTART = 16'h0200;
  localparam logic [15:0] CT_COL_TEST   = 16'h0080;

  localparam int ST_AN_CPL_BIT = 5;
  localparam int ST_LINK_BIT   = 2;
  localparam int DG_FDX_BIT    = 11;
  localparam int DG_100_BIT    = 10;

  localparam logic [15:0] AB_100F = 16'h0100;
  localparam logic [15:0] AB_100H = 16'h0080;
  localparam logic [15:0] AB_10F  = 16'h0040;
  localparam logic [15:0] AB_10H  = 16'h0020;

  typedef struct packed {
    logic        wr;
    logic [4:0]  ra;
    logic [15:0] wd;
  } acc_t;

  function automatic logic [15:0] adv_mix(logic [15:0] v, logic want100, logic wantfd);
    logic [15:0] r;
    r = v | AB_100F | AB_100H | AB_10F | AB_10H;
    if (!want100) r = r & ~(AB_100F | AB_100H);
    if (!wantfd)  r = r & ~(AB_100F | AB_10F);
    return r;
  endfunction

endpackage

// File: rtl/phy_mgr_xact.sv
module phy_mgr_xact
  import phy_mgr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  acc_t        acc,
  input  logic [4:0]  pa,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic [15:0] mdio_rdata,
  output logic        fin,
  output logic [15:0] rd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mdio_req   <= 1'b0;
      mdio_wr    <= 1'b0;
      mdio_phy   <= 5'd0;
      mdio_reg   <= 5'd0;
      mdio_wdata <= 16'd0;
      fin        <= 1'b0;
      rd         <= 16'd0;
    end else begin
      fin <= 1'b0;
      if (!mdio_req && go) begin
        mdio_req   <= 1'b1;
        mdio_wr    <= acc.wr;
        mdio_phy   <= pa;
        mdio_reg   <= acc.ra;
        mdio_wdata <= acc.wd;
      end else if (mdio_req && mdio_done) begin
        mdio_req <= 1'b0;
        fin      <= 1'b1;
        rd       <= mdio_rdata;
      end
    end
  end

endmodule

// File: rtl/phy_mgr_gap.sv
module phy_mgr_gap #(
  parameter int GAP = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);

  generate
    if (GAP == 0) begin : g_nowait
      always_ff @(posedge clk) begin
        if (rst) fire <= 1'b0;
        else     fire <= start;
      end
    end else begin : g_count
      localparam int CW = $clog2(GAP + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          fire <= 1'b0;
        end else if (start) begin
          cnt  <= CW'(GAP);
          fire <= 1'b0;
        end else if (cnt != '0) begin
          cnt  <= cnt - 1'b1;
          fire <= (cnt == CW'(1));
        end else begin
          fire <= 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/phy_mgr_seq.sv
module phy_mgr_seq
  import phy_mgr_pkg::*;
#(
  parameter int ADDR_MIN   = 1,
  parameter int ADDR_MAX   = 31,
  parameter int POLL_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_arg,
  output logic        cmd_ready,
  output logic        cmd_done,
  output logic [15:0] rsp_data,
  output logic        go,
  output acc_t        acc,
  output logic [4:0]  pa,
  input  logic        fin,
  input  logic [15:0] rd,
  output logic        gap_start,
  input  logic        gap_fire,
  output logic [7:0]  addr_out,
  output logic        phy_absent,
  output logic        link_up,
  output logic        spd_100,
  output logic        full_dup,
  output logic        an_done,
  output logic        an_timeout
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [4:0] A_LO = 5'(ADDR_MIN);
  localparam logic [4:0] A_HI = 5'(ADDR_MAX);
  localparam logic [PW-1:0] P_LAST = PW'(POLL_LIMIT - 1);

  typedef enum logic [4:0] {
    S_IDLE, S_PRB_RD, S_RST_W1, S_RST_W2, S_AN_RD, S_AN_WR, S_AN_POLL,
    S_AN_DLY, S_LNK_RD, S_TYP_RD, S_ADV_RD, S_ADV_WR, S_LB_RD, S_LB_WR,
    S_LB_RB
  } st_t;

  st_t           st;
  logic          issued;
  logic [4:0]    cur;
  logic [15:0]   hold;
  logic [1:0]    arg_q;
  logic [PW-1:0] polls;
  logic          acc_state;

  assign cmd_ready = (st == S_IDLE);
  assign pa        = cur;

  always_comb begin
    acc       = '{wr: 1'b0, ra: RA_CTRL, wd: 16'd0};
    acc_state = 1'b1;
    case (st)
      S_PRB_RD:  acc.ra = RA_ID1;
      S_RST_W1:  acc = '{wr: 1'b1, ra: RA_CTRL, wd: CT_SOFT_RST};
      S_RST_W2:  acc = '{wr: 1'b1, ra: RA_CTRL, wd: CT_AN_EN | CT_AN_RESTART | CT_COL_TEST};
      S_AN_RD:   acc.ra = RA_CTRL;
      S_AN_WR:   acc = '{wr: 1'b1, ra: RA_CTRL, wd: hold};
      S_AN_POLL: acc.ra = RA_STAT;
      S_LNK_RD:  acc.ra = RA_STAT;
      S_TYP_RD:  acc.ra = RA_DIAG;
      S_ADV_RD:  acc.ra = RA_ADV;
      S_ADV_WR:  acc = '{wr: 1'b1, ra: RA_ADV, wd: hold};
      S_LB_RD:   acc.ra = RA_CTRL;
      S_LB_WR:   acc = '{wr: 1'b1, ra: RA_CTRL, wd: hold};
      S_LB_RB:   acc.ra = RA_CTRL;
      default:   acc_state = 1'b0;
    endcase
    go = acc_state && !issued;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      issued     <= 1'b0;
      cur        <= A_LO;
      hold       <= 16'd0;
      arg_q      <= 2'd0;
      polls      <= '0;
      cmd_done   <= 1'b0;
      gap_start  <= 1'b0;
      rsp_data   <= 16'd0;
      addr_out   <= 8'hFF;
      phy_absent <= 1'b1;
      link_up    <= 1'b0;
      spd_100    <= 1'b0;
      full_dup   <= 1'b0;
      an_done    <= 1'b0;
      an_timeout <= 1'b0;
    end else begin
      cmd_done  <= 1'b0;
      gap_start <= 1'b0;
      if (go) issued <= 1'b1;
      if (fin) issued <= 1'b0;
      case (st)
        S_IDLE: begin
          issued <= 1'b0;
          if (cmd_valid) begin
            arg_q <= cmd_arg;
            case (op_t'(cmd_op))
              OP_PROBE:  begin cur <= A_LO; st <= S_PRB_RD; end
              OP_RESET:  st <= S_RST_W1;
              OP_ANEG:   begin
                polls      <= '0;
                an_done    <= 1'b0;
                an_timeout <= 1'b0;
                st         <= S_AN_RD;
              end
              OP_LINK:   st <= S_LNK_RD;
              OP_SPEED:  st <= S_TYP_RD;
              OP_ADVERT: st <= S_ADV_RD;
              OP_LOOP:   st <= S_LB_RD;
              default:   cmd_done <= 1'b1;
            endcase
          end
        end
        S_PRB_RD: if (fin) begin
          if (rd != 16'hFFFF && rd != 16'h0000) begin
            addr_out   <= {3'b000, cur};
            phy_absent <= 1'b0;
            st         <= S_IDLE;
            cmd_done   <= 1'b1;
          end else if (cur == A_HI) begin
            addr_out   <= 8'hFF;
            phy_absent <= 1'b1;
            st         <= S_IDLE;
            cmd_done   <= 1'b1;
          end else begin
            cur <= cur + 5'd1;
          end
        end
        S_RST_W1: if (fin) st <= S_RST_W2;
        S_RST_W2: if (fin) begin st <= S_IDLE; cmd_done <= 1'b1; end
        S_AN_RD: if (fin) begin
          hold <= rd | CT_AN_EN | CT_AN_RESTART;
          st   <= S_AN_WR;
        end
        S_AN_WR: if (fin) st <= S_AN_POLL;
        S_AN_POLL: if (fin) begin
          if (rd[ST_AN_CPL_BIT]) begin
            an_done  <= 1'b1;
            st       <= S_IDLE;
            cmd_done <= 1'b1;
          end else if (polls == P_LAST) begin
            an_timeout <= 1'b1;
            st         <= S_IDLE;
            cmd_done   <= 1'b1;
          end else begin
            polls     <= polls + 1'b1;
            gap_start <= 1'b1;
            st        <= S_AN_DLY;
          end
        end
        S_AN_DLY: if (gap_fire) st <= S_AN_POLL;
        S_LNK_RD: if (fin) begin
          link_up  <= rd[ST_LINK_BIT];
          st       <= S_IDLE;
          cmd_done <= 1'b1;
        end
        S_TYP_RD: if (fin) begin
          full_dup <= rd[DG_FDX_BIT];
          spd_100  <= rd[DG_100_BIT];
          st       <= S_IDLE;
          cmd_done <= 1'b1;
        end
        S_ADV_RD: if (fin) begin
          hold <= adv_mix(rd, arg_q[1], arg_q[0]);
          st   <= S_ADV_WR;
        end
        S_ADV_WR: if (fin) begin st <= S_IDLE; cmd_done <= 1'b1; end
        S_LB_RD: if (fin) begin
          hold <= arg_q[0] ? (rd | CT_LOOP) : (rd & ~CT_LOOP);
          st   <= S_LB_WR;
        end
        S_LB_WR: if (fin) st <= S_LB_RB;
        S_LB_RB: if (fin) begin
          rsp_data <= rd;
          st       <= S_IDLE;
          cmd_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_link_mgr.sv
module phy_link_mgr
  import phy_mgr_pkg::*;
#(
  parameter int ADDR_MIN   = 1,
  parameter int ADDR_MAX   = 31,
  parameter int POLL_GAP   = 200,
  parameter int POLL_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_arg,
  output logic        cmd_ready,
  output logic        cmd_done,
  output logic [15:0] rsp_data,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic [15:0] mdio_rdata,
  output logic [7:0]  addr_out,
  output logic        phy_absent,
  output logic        link_up,
  output logic        spd_100,
  output logic        full_dup,
  output logic        an_done,
  output logic        an_timeout
);

  logic        go, fin, gap_start, gap_fire;
  acc_t        acc;
  logic [4:0]  pa;
  logic [15:0] rd;

  phy_mgr_seq #(
    .ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .rsp_data(rsp_data), .go(go), .acc(acc), .pa(pa), .fin(fin), .rd(rd),
    .gap_start(gap_start), .gap_fire(gap_fire), .addr_out(addr_out),
    .phy_absent(phy_absent), .link_up(link_up), .spd_100(spd_100),
    .full_dup(full_dup), .an_done(an_done), .an_timeout(an_timeout)
  );

  phy_mgr_xact u_xact (
    .clk(clk), .rst(rst), .go(go), .acc(acc), .pa(pa),
    .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
    .mdio_rdata(mdio_rdata), .fin(fin), .rd(rd)
  );

  phy_mgr_gap #(.GAP(POLL_GAP)) u_gap (
    .clk(clk), .rst(rst), .start(gap_start), .fire(gap_fire)
  );

endmodule

// File: rtl/phy_link_mgr_chk.sv
module phy_link_mgr_chk #(
  parameter int ADDR_MIN = 1,
  parameter int ADDR_MAX = 31
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_ready,
  input logic        cmd_done,
  input logic        mdio_req,
  input logic        mdio_done,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic [7:0]  addr_out,
  input logic        phy_absent,
  input logic        an_done,
  input logic        an_timeout
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_reg) && $stable(mdio_wdata) && $stable(mdio_phy))); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mdio_req); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> cmd_ready); // R12

  AST_ABSENT_MARK: assert property (@(posedge clk) disable iff (rst)
    phy_absent |-> (addr_out == 8'hFF)); // R3

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    !phy_absent |-> (addr_out >= 8'(ADDR_MIN) && addr_out <= 8'(ADDR_MAX))); // R1

  AST_AN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(an_done && an_timeout)); // R7

endmodule

bind phy_link_mgr phy_link_mgr_chk #(.ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX)) u_chk (.*);

// File: tb/sim_phy_link_mgr.sv
`timescale 1ns/1ps
module sim_phy_link_mgr;
  localparam int AMIN = 1, AMAX = 6, GAP = 20, PL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_arg = 2'd0;
  logic cmd_ready, cmd_done;
  logic [15:0] rsp_data;
  logic mdio_req, mdio_wr, mdio_done;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata;
  logic [7:0] addr_out;
  logic phy_absent, link_up, spd_100, full_dup, an_done, an_timeout;

  always #4 clk = ~clk;

  phy_link_mgr #(.ADDR_MIN(AMIN), .ADDR_MAX(AMAX), .POLL_GAP(GAP), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done), .rsp_data(rsp_data),
    .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .addr_out(addr_out), .phy_absent(phy_absent), .link_up(link_up), .spd_100(spd_100),
    .full_dup(full_dup), .an_done(an_done), .an_timeout(an_timeout));

  int n_chk = 0, n_bad = 0, cyc = 0;

  // PHY model state
  logic [15:0] regs [32];
  int phy_at = 4;
  int anc_after = 1;
  logic link_bit = 1'b0;
  int r1_reads = 0, last_r1 = 0, min_gap = 1000000;
  int probe_lo = 99, probe_hi = -1;
  logic [15:0] wlog [4];
  int wcnt = 0;
  int hs_bad = 0;
  bit m_busy = 0;
  int m_wait = 0;

  initial begin
    mdio_done = 1'b0;
    mdio_rdata = 16'd0;
    for (int i = 0; i < 32; i++) regs[i] = 16'd0;
  end

  function automatic logic [15:0] peek(input int pa, input int ra);
    logic [15:0] v;
    if (pa != phy_at) v = (ra == 2 && pa == 2) ? 16'h0000 : 16'hFFFF;
    else if (ra == 1) begin
      v = regs[1];
      v[5] = (r1_reads >= anc_after);
      v[2] = link_bit;
    end else v = regs[ra];
    return v;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mdio_done <= 1'b0;
    if (rst) m_busy = 0;
    else if (m_busy) begin
      if (!mdio_req) hs_bad++;
      if (m_wait > 0) m_wait--;
      else begin
        if (mdio_wr) begin
          if (int'(mdio_phy) == phy_at) regs[mdio_reg] = mdio_wdata;
          if (mdio_reg == 5'd0 && wcnt < 4) begin wlog[wcnt] = mdio_wdata; wcnt++; end
        end else begin
          if (mdio_reg == 5'd2) begin
            if (int'(mdio_phy) < probe_lo) probe_lo = int'(mdio_phy);
            if (int'(mdio_phy) > probe_hi) probe_hi = int'(mdio_phy);
          end
          if (mdio_reg == 5'd1 && int'(mdio_phy) == phy_at) begin
            r1_reads++;
            if (r1_reads > 1 && (cyc - last_r1) < min_gap) min_gap = cyc - last_r1;
            last_r1 = cyc;
          end
          mdio_rdata <= peek(int'(mdio_phy), int'(mdio_reg));
        end
        mdio_done <= 1'b1;
        m_busy = 0;
      end
    end else if (mdio_req && !mdio_done) begin
      m_busy = 1;
      m_wait = 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] arg);
    int n = 0;
    chk("R12 ready before command", {15'd0, cmd_ready}, 16'd1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_done && n < 5000) begin @(negedge clk); n++; end
    chk("R12 command completes", {15'd0, cmd_done}, 16'd1);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R3 reset addr", {8'd0, addr_out}, 16'h00FF);
    chk("R3 reset absent", {15'd0, phy_absent}, 16'd1);
    chk("R12 reset ready", {15'd0, cmd_ready}, 16'd1);
    chk("R12 reset flags", {11'd0, link_up, spd_100, full_dup, an_done, an_timeout}, 16'd0);
  endtask

  task automatic t_probe_none();
    phy_at = 20; probe_lo = 99; probe_hi = -1;
    do_cmd(3'd0, 2'd0);
    chk("R3 none addr", {8'd0, addr_out}, 16'h00FF);
    chk("R3 none absent", {15'd0, phy_absent}, 16'd1);
    chk("R1 none scans to max", 16'(probe_hi), 16'(AMAX));
  endtask

  task automatic t_probe_found();
    phy_at = 4; regs[2] = 16'h2000; probe_lo = 99; probe_hi = -1;
    do_cmd(3'd0, 2'd0);
    chk("R1 found addr", {8'd0, addr_out}, 16'd4);
    chk("R1 found absent", {15'd0, phy_absent}, 16'd0);
    chk("R1 first address", 16'(probe_lo), 16'(AMIN));
    chk("R2 ones/zeros skipped, stop at hit", 16'(probe_hi), 16'd4);
  endtask

  task automatic t_reset_cmd();
    wcnt = 0;
    do_cmd(3'd1, 2'd0);
    chk("R4 write count", 16'(wcnt), 16'd2);
    chk("R4 first write", wlog[0], 16'h8000);
    chk("R4 second write", wlog[1], 16'h1280);
  endtask

  task automatic t_aneg();
    regs[0] = 16'h0100; wcnt = 0; r1_reads = 0; min_gap = 1000000; anc_after = 3;
    do_cmd(3'd2, 2'd0);
    chk("R5 rmw value", wlog[0], 16'h1300);
    chk("R5 an_done", {15'd0, an_done}, 16'd1);
    chk("R5 poll count", 16'(r1_reads), 16'd3);
    chk("R6 gap at least POLL_GAP", {15'd0, min_gap >= GAP}, 16'd1);
    chk("R7 no timeout", {15'd0, an_timeout}, 16'd0);
  endtask

  task automatic t_aneg_timeout();
    r1_reads = 0; anc_after = 1000;
    do_cmd(3'd2, 2'd0);
    chk("R7 timeout flag", {15'd0, an_timeout}, 16'd1);
    chk("R7 no done", {15'd0, an_done}, 16'd0);
    chk("R7 reads equal limit", 16'(r1_reads), 16'(PL));
  endtask

  task automatic t_link();
    anc_after = 0;
    link_bit = 1'b1; do_cmd(3'd3, 2'd0);
    chk("R8 link up", {15'd0, link_up}, 16'd1);
    link_bit = 1'b0; do_cmd(3'd3, 2'd0);
    chk("R8 link down", {15'd0, link_up}, 16'd0);
  endtask

  task automatic t_speed();
    regs[5'h12] = 16'h0800; do_cmd(3'd4, 2'd0);
    chk("R9 fdx only", {14'd0, full_dup, spd_100}, 16'b10);
    regs[5'h12] = 16'h0400; do_cmd(3'd4, 2'd0);
    chk("R9 100 only", {14'd0, full_dup, spd_100}, 16'b01);
  endtask

  task automatic t_adv();
    regs[4] = 16'h0001; do_cmd(3'd5, 2'b01);
    chk("R10 10M full", regs[4], 16'h0061);
    regs[4] = 16'h0001; do_cmd(3'd5, 2'b11);
    chk("R10 all", regs[4], 16'h01E1);
    regs[4] = 16'h0001; do_cmd(3'd5, 2'b10);
    chk("R10 100M half", regs[4], 16'h00A1);
  endtask

  task automatic t_loop();
    regs[0] = 16'h1000;
    do_cmd(3'd6, 2'b01);
    chk("R11 enable rsp", rsp_data, 16'h5000);
    do_cmd(3'd6, 2'b00);
    chk("R11 disable rsp", rsp_data, 16'h1000);
    do_cmd(3'd6, 2'b00);
    chk("R11 second disable stays clear", rsp_data, 16'h1000);
    chk("R11 register value", regs[0], 16'h1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_probe_none();
    t_probe_found();
    t_reset_cmd();
    t_aneg();
    t_aneg_timeout();
    t_link();
    t_speed();
    t_adv();
    t_loop();
    chk("R13 request held until done", 16'(hs_bad), 16'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R12 actual=%0d expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule